// File: doc/BRIEF.md
# Single-Channel SPI Chip-Select Controller

This block drives the chip-select (enable) line of an SPI master when the master runs with a single channel. Software enables channels one at a time. The block tracks which channel owns the line and sets the line level from that channel's polarity and force bits. It also tells the serializer when to begin a word.

There are two pin modes. In 4-pin mode, software holds the line active or idle with the force bit, and the polarity bit inverts it. Because the line holds its level while no channel is enabled, the line can stay active across several configure, enable and disable rounds. In 3-pin mode, the force bit has no effect and the line rests at its idle level. In both modes a word starts whenever transmit data is waiting and no word is running.

The block also enforces the channel switch order: wait for end-of-word, disable the old channel, then enable the new one. An enable that breaks this order is refused and leaves a sticky error flag.

Top module: `spi_cs_ctrl`

## Requirements
- R1: After synchronous reset, `cs_out` is 1 (the parameter CS_RST), and `word_start`, `seq_err` and `ch_en` are all 0.
- R2: A 0-to-1 change on `ch_en_req[i]` is accepted when no channel is enabled, no word is running and no other request rises in the same cycle. `ch_en[i]` is then 1 after the next clock edge. It stays 1 while the request is held and clears one edge after the request drops.
- R3: A rising request on a channel is ignored and `seq_err` is set one edge later in any of these cases: another channel is enabled, a word is running, or two or more requests rise together. The refused channel stays disabled while its request is held. `seq_err` stays 1 until reset.
- R4: In 4-pin mode (`three_pin`=0, `single_mode`=1) with channel i enabled, one edge later `cs_out` is `ch_frc[i]` XOR `ch_pol[i]`. So force 1 gives high with polarity 0 and low with polarity 1.
- R5: In 3-pin mode (`three_pin`=1, `single_mode`=1) with channel i enabled, one edge later `cs_out` equals `ch_pol[i]`, the idle level, whatever the force bit is.
- R6: In single-channel mode with no channel enabled, `cs_out` keeps its last value. This lets the line stay active between a disable and the next enable.
- R7: `word_start` is a one-cycle pulse. It is raised when all of these hold: single-channel mode, a channel enabled, `tx_not_empty` high and no word running. A word runs from the pulse until the cycle in which `word_done` is sampled high, and no new pulse occurs while it runs.
- R8: With `single_mode`=0, `cs_out` goes to CS_RST one edge later and no `word_start` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| single_mode | input | 1 | 1 = single-channel master operation |
| three_pin | input | 1 | 1 = 3-pin mode, 0 = 4-pin mode |
| ch_pol | input | N_CH | Per-channel polarity bit |
| ch_frc | input | N_CH | Per-channel force bit |
| ch_en_req | input | N_CH | Per-channel enable written by software |
| tx_not_empty | input | 1 | Transmit register or FIFO holds data |
| word_done | input | 1 | End-of-word flag from the serializer |
| cs_out | output | 1 | Chip-select line level (registered) |
| word_start | output | 1 | One-cycle strobe that starts a word |
| ch_en | output | N_CH | Enables accepted by the block |
| seq_err | output | 1 | Sticky channel-switch order error |

## Verification
The hardest case to reach from the ports is a refused enable caused by a running word rather than by another enabled channel. The bench reaches it by starting a word on channel 0 and dropping channel 0's enable while `word_done` is still low. It then raises channel 1, whose refusal can only come from the busy state. The keep-active case is reached in the same way: the line is driven to the active level through force, the channel is disabled and the force bit changed, and `cs_out` is observed to hold until a new channel is accepted.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic {
    PINS_FOUR  = 1'b0,
    PINS_THREE = 1'b1
  } pin_mode_e;
endpackage

// File: rtl/spi_cs_enable_track.sv
module spi_cs_enable_track #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] en_req,
  input  logic            busy,
  output logic [N_CH-1:0] act,
  output logic            err
);
  logic [N_CH-1:0] req_q;
  logic [N_CH-1:0] rise;
  logic [N_CH-1:0] accept;
  logic [N_CH-1:0] act_n;
  logic            multi_rise;
  logic            any_act;

  assign rise       = en_req & ~req_q;
  assign multi_rise = (rise & (rise - 1'b1)) != '0;
  assign any_act    = |act;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign accept[i] = rise[i] & ~any_act & ~busy & ~multi_rise;
    assign act_n[i]  = en_req[i] & (act[i] | accept[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
      act   <= '0;
      err   <= 1'b0;
    end else begin
      req_q <= en_req;
      act   <= act_n;
      if (|(rise & ~accept)) err <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_cs_word_ctl.sv
module spi_cs_word_ctl #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            single_mode,
  input  logic [N_CH-1:0] act,
  input  logic            tx_not_empty,
  input  logic            word_done,
  output logic            busy,
  output logic            start
);
  logic start_cond;

  assign start_cond = single_mode & (|act) & tx_not_empty & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      start <= 1'b0;
    end else begin
      start <= start_cond;
      if (start_cond)     busy <= 1'b1;
      else if (word_done) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_cs_level.sv
module spi_cs_level
  import spi_cs_pkg::*;
#(
  parameter int   N_CH   = 4,
  parameter logic CS_RST = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            single_mode,
  input  pin_mode_e       pin_mode,
  input  logic [N_CH-1:0] act,
  input  logic [N_CH-1:0] pol,
  input  logic [N_CH-1:0] frc,
  output logic            cs
);
  logic sel_pol;
  logic sel_frc;

  assign sel_pol = |(act & pol);
  assign sel_frc = |(act & frc);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs <= CS_RST;
    end else if (!single_mode) begin
      cs <= CS_RST;
    end else if (|act) begin
      if (pin_mode == PINS_THREE) cs <= sel_pol;
      else                        cs <= sel_frc ^ sel_pol;
    end
  end
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
  import spi_cs_pkg::*;
#(
  parameter int   N_CH   = 4,
  parameter logic CS_RST = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            single_mode,
  input  logic            three_pin,
  input  logic [N_CH-1:0] ch_pol,
  input  logic [N_CH-1:0] ch_frc,
  input  logic [N_CH-1:0] ch_en_req,
  input  logic            tx_not_empty,
  input  logic            word_done,
  output logic            cs_out,
  output logic            word_start,
  output logic [N_CH-1:0] ch_en,
  output logic            seq_err
);
  logic      busy;
  pin_mode_e pin_mode;

  assign pin_mode = three_pin ? PINS_THREE : PINS_FOUR;

  spi_cs_enable_track #(.N_CH(N_CH)) u_track (
    .clk(clk), .rst(rst), .en_req(ch_en_req), .busy(busy),
    .act(ch_en), .err(seq_err)
  );

  spi_cs_word_ctl #(.N_CH(N_CH)) u_word (
    .clk(clk), .rst(rst), .single_mode(single_mode), .act(ch_en),
    .tx_not_empty(tx_not_empty), .word_done(word_done),
    .busy(busy), .start(word_start)
  );

  spi_cs_level #(.N_CH(N_CH), .CS_RST(CS_RST)) u_level (
    .clk(clk), .rst(rst), .single_mode(single_mode), .pin_mode(pin_mode),
    .act(ch_en), .pol(ch_pol), .frc(ch_frc), .cs(cs_out)
  );
endmodule

// File: rtl/spi_cs_ctrl_chk.sv
module spi_cs_ctrl_chk #(
  parameter int   N_CH   = 4,
  parameter logic CS_RST = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic            single_mode,
  input logic            three_pin,
  input logic [N_CH-1:0] ch_pol,
  input logic [N_CH-1:0] ch_frc,
  input logic [N_CH-1:0] ch_en_req,
  input logic            cs_out,
  input logic            word_start,
  input logic [N_CH-1:0] ch_en,
  input logic            seq_err
);
  logic [N_CH-1:0] req_seen;

  always_ff @(posedge clk) begin
    if (rst) req_seen <= '0;
    else     req_seen <= ch_en_req;
  end

  p_sticky_err_r3: assert property (@(posedge clk) disable iff (rst)
    seq_err |=> seq_err);

  p_one_owner_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_en));

  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    word_start |=> !word_start);

  p_multi_off_r8: assert property (@(posedge clk) disable iff (rst)
    !single_mode |=> (!word_start && cs_out == CS_RST));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (single_mode && ch_en == '0) |=> $stable(cs_out));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    p_refuse_r3: assert property (@(posedge clk) disable iff (rst)
      (ch_en_req[i] && !req_seen[i] && ch_en != '0) |=> (!ch_en[i] && seq_err));

    p_four_pin_r4: assert property (@(posedge clk) disable iff (rst)
      (single_mode && !three_pin && ch_en[i])
        |=> cs_out == $past(ch_frc[i] ^ ch_pol[i]));

    p_three_pin_r5: assert property (@(posedge clk) disable iff (rst)
      (single_mode && three_pin && ch_en[i]) |=> cs_out == $past(ch_pol[i]));
  end
endmodule

bind spi_cs_ctrl spi_cs_ctrl_chk #(.N_CH(N_CH), .CS_RST(CS_RST)) u_chk (
  .clk(clk), .rst(rst), .single_mode(single_mode), .three_pin(three_pin),
  .ch_pol(ch_pol), .ch_frc(ch_frc), .ch_en_req(ch_en_req), .cs_out(cs_out),
  .word_start(word_start), .ch_en(ch_en), .seq_err(seq_err)
);

// File: tb/sim_spi_cs_ctrl.sv
`timescale 1ns/1ps
module sim_spi_cs_ctrl;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         single_mode, three_pin, tx_not_empty, word_done;
  logic [N-1:0] ch_pol, ch_frc, ch_en_req, ch_en;
  logic         cs_out, word_start, seq_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  spi_cs_ctrl #(.N_CH(N), .CS_RST(1'b1)) u0 (
    .clk(clk), .rst(rst), .single_mode(single_mode), .three_pin(three_pin),
    .ch_pol(ch_pol), .ch_frc(ch_frc), .ch_en_req(ch_en_req),
    .tx_not_empty(tx_not_empty), .word_done(word_done),
    .cs_out(cs_out), .word_start(word_start), .ch_en(ch_en), .seq_err(seq_err)
  );

  // {three_pin, force, polarity, expected cs}
  localparam logic [3:0] VEC [8] = '{
    4'b0000, 4'b0011, 4'b0101, 4'b0110,
    4'b1000, 4'b1011, 4'b1100, 4'b1111
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ch_en_req = '0; ch_frc = '0; ch_pol = '0;
    tx_not_empty = 1'b0; word_done = 1'b0; single_mode = 1'b1; three_pin = 1'b0;
    tick(2);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 cs", cs_out, 1);
    check("R1 start", word_start, 0);
    check("R1 err", seq_err, 0);
    check("R1 en", ch_en, 0);

    // R2 accept first enable
    ch_en_req = 4'b0001;
    tick(1);
    check("R2 accept", ch_en, 4'b0001);

    // R4 / R5 level table on channel 0
    for (int v = 0; v < 8; v++) begin
      three_pin = VEC[v][3];
      ch_frc[0] = VEC[v][2];
      ch_pol[0] = VEC[v][1];
      tick(2);
      check(VEC[v][3] ? "R5 level" : "R4 level", cs_out, VEC[v][0]);
    end

    // R6 hold across disable/enable
    three_pin = 1'b0; ch_frc[0] = 1'b0; ch_pol[0] = 1'b0;
    tick(2);
    check("R4 low", cs_out, 0);
    ch_en_req = '0;
    tick(1);
    check("R2 drop", ch_en, 0);
    ch_frc[0] = 1'b1; ch_pol[0] = 1'b1; ch_pol[1] = 1'b1;
    tick(3);
    check("R6 hold", cs_out, 0);
    ch_en_req = 4'b0010;
    ch_frc[1] = 1'b0;
    tick(2);
    check("R2 ch1", ch_en, 4'b0010);
    check("R6 new owner", cs_out, 1);

    // R3 refuse while another enabled
    ch_en_req = 4'b0110;
    tick(1);
    check("R3 refused", ch_en, 4'b0010);
    check("R3 err", seq_err, 1);
    ch_en_req = 4'b0100;
    tick(2);
    check("R3 held refused", ch_en, 0);
    check("R3 sticky", seq_err, 1);

    // R3 simultaneous rises
    do_reset();
    ch_en_req = 4'b0011;
    tick(1);
    check("R3 double", ch_en, 0);
    check("R3 double err", seq_err, 1);

    // R7 word start and R3 busy refusal
    do_reset();
    ch_en_req = 4'b0001;
    tx_not_empty = 1'b1;
    tick(2);
    check("R7 start", word_start, 1);
    tick(1);
    check("R7 pulse", word_start, 0);
    tick(3);
    check("R7 busy", word_start, 0);
    tx_not_empty = 1'b0;
    ch_en_req = 4'b0000;
    tick(1);
    ch_en_req = 4'b0010;
    tick(1);
    check("R3 busy refused", ch_en, 0);
    check("R3 busy err", seq_err, 1);
    ch_en_req = 4'b0000;
    do_reset();
    ch_en_req = 4'b0001;
    tx_not_empty = 1'b1;
    tick(2);
    check("R7 start2", word_start, 1);
    tick(2);
    word_done = 1'b1;
    tick(1);
    check("R7 done cycle", word_start, 0);
    word_done = 1'b0;
    tick(1);
    check("R7 restart", word_start, 1);

    // R8 multi-channel mode
    word_done = 1'b1;
    tick(1);
    word_done = 1'b0;
    single_mode = 1'b0;
    ch_frc[0] = 1'b0; ch_pol[0] = 1'b0;
    tick(1);
    check("R8 cs", cs_out, 1);
    tick(3);
    check("R8 no start", word_start, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule